// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

An 8-bit presettable counter fed by a single input pin. In edge-counting mode it advances once per selected transition of the pin. In gated-timer mode it advances once every 64 system clocks, but only while the pin sits at its enabling level. When the pin leaves that level the count holds, and counting picks up again from the held value when the level returns. A single polarity bit picks the counted edge in the first mode and the inhibiting level in the second.

Software programs a 5-bit control word (enable, mode, polarity, two interrupt enables) and may load the counter at any time. A typical use is to preload the two's complement of a count, so that a wrap flag marks the end. Preloading a value halfway between two pulse widths in gated mode gives a pulse-width discriminator: whichever flag rises first, wrap or end-of-level, tells a wide pulse from a narrow one. Two sticky flags, wrap and input-edge, are cleared by writing ones. Each flag has its own enable into a shared interrupt line.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0x00, both flags are 0, the interrupt is 0 and the control word is 0 (disabled), so pin activity changes nothing.
- R2: With the enable bit (control bit 0) at 0, pin activity neither changes the count nor sets any flag. The count can still be loaded.
- R3: With mode (control bit 1) at 0, the count rises by one per selected pin edge. Polarity (control bit 2) at 0 selects falling edges and at 1 selects rising edges. The count is visible two clocks after the pin changes.
- R4: With mode at 1, the count rises by one on each tick of a divide-by-64 timebase while the pin is at its enabling level. The pin is enabling when high for polarity 0 and when low for polarity 1. An enabling window of 64·N clocks yields exactly N increments.
- R5: In gated mode the count holds while the pin is at the inhibiting level and resumes from the held value when the enabling level returns.
- R6: An increment from 0xFF produces 0x00 and sets the wrap flag.
- R7: The edge flag is set by the polarity-selected edge, which is falling for polarity 0 and rising for polarity 1. In gated mode this is the edge that ends the enabling level. The opposite edge does not set it.
- R8: Writing to the flag register (select 2) clears the wrap flag where data bit 0 is 1 and the edge flag where data bit 1 is 1. A flag set in the same cycle as its clear stays set.
- R9: The interrupt output is high when (wrap flag AND control bit 3) OR (edge flag AND control bit 4), and low otherwise.
- R10: A write to the count (select 1) takes priority over an increment in the same cycle. The written value appears with no increment added.
- R11: The divide-by-64 timebase runs freely from reset and is never restarted by the pin. Over 64 consecutive windows of 33 enabling clocks at a 65-clock period, exactly 33 increments occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| pin_i | input | 1 | Accumulator input pin (synchronous to clk) |
| count_o | output | CNT_W | Current count |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| edge_flag_o | output | 1 | Sticky input-edge flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Most internal faults show on count_o within two clocks of the pin edge that should have moved it: a wrong edge decode, a wrong polarity or a lost enable. Timebase faults show only through the totals after long gated windows. The window lengths are therefore multiples of 64 clocks, or a sweep of all 64 phases, so that any phase gives an exact expected total. A prescaler restarted by the pin, or one with a wrong divisor, then shifts that total. Flag and interrupt faults show at once on the cycle after the causing edge or write. The same-cycle collision cases, load against increment and set against clear, are driven at the exact clock where both occur.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int PACC_CNT_W = 8;
    localparam int PACC_DIV   = 64;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_FLAGS = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } acc_mode_e;

    // bit 0 enable, bit 1 mode, bit 2 polarity, bit 3 wrap irq en, bit 4 edge irq en
    typedef struct packed {
        logic      edge_ie;
        logic      ovf_ie;
        logic      polarity;
        acc_mode_e mode;
        logic      enable;
    } acc_ctrl_t;

    localparam int CTRL_W = $bits(acc_ctrl_t);

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
    } pin_ev_t;

    // Edge selected by polarity: also the edge that ends the gated enabling level.
    function automatic logic sel_edge(pin_ev_t ev, logic polarity);
        return polarity ? ev.rise : ev.fall;
    endfunction

    // Enabling level in gated mode: high for polarity 0, low for polarity 1.
    function automatic logic gate_open(pin_ev_t ev, logic polarity);
        return ev.level ^ polarity;
    endfunction

endpackage

// File: rtl/pacc_pin_sense.sv
module pacc_pin_sense
    import pacc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_i,
    output pin_ev_t ev_o
);
    logic pin_d1;
    logic pin_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_d1 <= 1'b0;
            pin_d2 <= 1'b0;
        end else begin
            pin_d1 <= pin_i;
            pin_d2 <= pin_d1;
        end
    end

    always_comb begin
        ev_o.rise  = pin_d1 & ~pin_d2;
        ev_o.fall  = ~pin_d1 & pin_d2;
        ev_o.level = pin_d1;
    end

    p_one_edge_r3: assert property (@(posedge clk) disable iff (rst)
        !(ev_o.rise && ev_o.fall));

endmodule

// File: rtl/pacc_timebase.sv
module pacc_timebase #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TB_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [TB_W-1:0] LAST = TB_W'(DIV - 1);

    logic [TB_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                 phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + TB_W'(1);
    end

    assign tick_o = (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            p_tick_gap_r11: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (inc_i)  cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i & ~load_i & (&cnt_q);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(load_val_i));

    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !load_i) |=> cnt_q == $past(cnt_q) + W'(1));

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_q == '0);

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CNT_W = PACC_CNT_W,
    parameter int DIV   = PACC_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             pin_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_flag_o,
    output logic             edge_flag_o,
    output logic             irq_o
);
    localparam int FLAG_OVF_BIT  = 0;
    localparam int FLAG_EDGE_BIT = 1;

    acc_ctrl_t ctrl_q;
    pin_ev_t   ev;
    logic      tick;
    logic      wr_ctrl, wr_count, wr_flags;
    logic      inc, wrap, edge_hit;
    logic      ovf_q, edge_q;
    logic      ovf_clr, edge_clr;

    pacc_pin_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .ev_o  (ev)
    );

    pacc_timebase #(.DIV(DIV)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    always_comb begin
        wr_ctrl  = wr_en && (wr_sel_e'(wr_sel) == SEL_CTRL);
        wr_count = wr_en && (wr_sel_e'(wr_sel) == SEL_COUNT);
        wr_flags = wr_en && (wr_sel_e'(wr_sel) == SEL_FLAGS);
        ovf_clr  = wr_flags && wr_data[FLAG_OVF_BIT];
        edge_clr = wr_flags && wr_data[FLAG_EDGE_BIT];
        edge_hit = ctrl_q.enable && sel_edge(ev, ctrl_q.polarity);
        if (!ctrl_q.enable)
            inc = 1'b0;
        else if (ctrl_q.mode == MODE_EVENT)
            inc = sel_edge(ev, ctrl_q.polarity);
        else
            inc = tick && gate_open(ev, ctrl_q.polarity);
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= acc_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_count),
        .load_val_i (wr_data),
        .inc_i      (inc),
        .cnt_o      (count_o),
        .wrap_o     (wrap)
    );

    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            ovf_q  <= wrap     | (ovf_q  & ~ovf_clr);
            edge_q <= edge_hit | (edge_q & ~edge_clr);
        end
    end

    assign ovf_flag_o  = ovf_q;
    assign edge_flag_o = edge_q;
    assign irq_o       = (ovf_q & ctrl_q.ovf_ie) | (edge_q & ctrl_q.edge_ie);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !wr_count) |=> $stable(count_o));

    p_gate_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && ctrl_q.mode == MODE_GATED
         && !gate_open(ev, ctrl_q.polarity) && !wr_count) |=> $stable(count_o));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag_o);

    p_clear_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !wrap) |=> !ovf_flag_o);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag_o && !edge_flag_o) |-> !irq_o);

    p_edge_flag_r7: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> edge_flag_o);

endmodule

// File: tb/pulse_accum_tb_top.sv
module pulse_accum_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       pin_i = 1'b0;
    logic [7:0] count_o;
    logic       ovf_flag_o, edge_flag_o, irq_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pulse_accum dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pin_i(pin_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
        .edge_flag_o(edge_flag_o), .irq_o(irq_o)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic hold(logic lvl, int cycles);
        pin_i = lvl;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            hold(1'b1, 3);
            hold(1'b0, 3);
        end
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 ovf", ovf_flag_o, 0);
        chk("R1 edge", edge_flag_o, 0);
        chk("R1 irq", irq_o, 0);
        pulses(1);
        chk("R1 disabled after reset", count_o, 0);
    endtask

    task automatic t_event();
        wr(2'd0, 8'h05);
        pulses(3);
        chk("R3 rising count", count_o, 3);
        chk("R7 rising flag", edge_flag_o, 1);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        hold(1'b1, 3);
        chk("R3 falling mode ignores rise", count_o, 0);
        chk("R7 rise no flag in falling mode", edge_flag_o, 0);
        hold(1'b0, 3);
        chk("R3 falling count", count_o, 1);
        chk("R7 falling flag", edge_flag_o, 1);
        pulses(2);
        chk("R3 falling total", count_o, 3);
    endtask

    task automatic t_disabled();
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h03);
        pulses(3);
        chk("R2 no count", count_o, 3);
        chk("R2 no flag", edge_flag_o, 0);
        wr(2'd1, 8'h22);
        chk("R2 load while off", count_o, 8'h22);
    endtask

    task automatic t_wrap_irq();
        wr(2'd0, 8'h0D);
        wr(2'd1, 8'hFD);
        pulses(2);
        chk("R6 at FF", count_o, 8'hFF);
        chk("R6 no flag yet", ovf_flag_o, 0);
        chk("R9 irq low", irq_o, 0);
        pulses(1);
        chk("R6 wrapped", count_o, 0);
        chk("R6 flag", ovf_flag_o, 1);
        chk("R9 irq from wrap", irq_o, 1);
        wr(2'd0, 8'h05);
        chk("R9 masked", irq_o, 0);
        wr(2'd2, 8'h01);
        chk("R8 wrap cleared", ovf_flag_o, 0);
        chk("R8 edge kept", edge_flag_o, 1);
        wr(2'd0, 8'h15);
        chk("R9 irq from edge", irq_o, 1);
        wr(2'd2, 8'h02);
        chk("R8 edge cleared", edge_flag_o, 0);
        chk("R9 irq drops", irq_o, 0);
    endtask

    task automatic t_collide();
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h10);
        pin_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h40;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
        chk("R10 load beats inc", count_o, 8'h40);
        repeat (3) @(negedge clk);
        chk("R10 no late inc", count_o, 8'h40);
        hold(1'b0, 3);
        wr(2'd2, 8'h03);
        pin_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
        chk("R8 set beats clear", edge_flag_o, 1);
        hold(1'b0, 3);
    endtask

    task automatic t_gated();
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h03);
        hold(1'b1, 640);
        chk("R7 gated rise no flag", edge_flag_o, 0);
        hold(1'b0, 3);
        chk("R4 ten ticks", count_o, 10);
        chk("R7 gated end flag", edge_flag_o, 1);
        hold(1'b0, 200);
        chk("R5 frozen", count_o, 10);
        hold(1'b1, 640);
        hold(1'b0, 3);
        chk("R5 resumed", count_o, 20);
        hold(1'b1, 3);
        wr(2'd0, 8'h07);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h03);
        hold(1'b0, 320);
        chk("R7 polarity1 fall no flag", edge_flag_o, 0);
        hold(1'b1, 300);
        chk("R4 active low five ticks", count_o, 5);
        chk("R7 polarity1 end flag", edge_flag_o, 1);
    endtask

    task automatic t_phase_sweep();
        hold(1'b0, 3);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        for (int k = 0; k < 64; k++) begin
            hold(1'b1, 33);
            hold(1'b0, 32);
        end
        hold(1'b0, 3);
        chk("R11 free running timebase", count_o, 33);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_event();
        t_disabled();
        t_wrap_irq();
        t_collide();
        t_gated();
        t_phase_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule